// File: doc/BRIEF.md
# Step Direction Reversal Ready Gate

This block holds a drive's active-low ready output inactive for a fixed settling interval each time the head stepping direction reverses. It watches two asynchronous lines: a step strobe that rests high and pulses low, and a direction level. The direction is sampled on every trailing (low-to-high) edge of the strobe, and each new sample is compared with the sample taken on the strobe before it.

When the two samples differ, a single-cycle registered pulse is issued. That pulse reloads a down-counter to its full hold-off count, even if the counter is still running, so every reversal restarts the interval. This includes reversals on back-to-back strobes. Coming out of reset is treated like a reversal, so the hold-off runs once right after reset is released. The first strobe after reset only sets the reference direction. The hold-off length is given in microseconds, together with the system clock frequency, and is turned into a whole number of clock cycles.

Top module: `dirrev_ready_gate`

## Requirements
- R1: `ready_n` is active low. It is high (not ready) while the hold-off count is nonzero and low once the count reaches zero.
- R2: While `rst_n` is low, `ready_n` is 1 and `rev_pulse` is 0. After release, `ready_n` stays high for exactly RELOAD clock edges and then falls, so start-up behaves as a reversal.
- R3: `step_n` and `dir` each pass through two synchronizing flops. If a strobe rising edge is present at the inputs before clock edge k, the resulting `rev_pulse` is high after edge k+2.
- R4: A falling strobe edge, and any direction change while the strobe does not rise, does not produce `rev_pulse`. Only the direction present at a rising strobe edge is compared.
- R5: The first rising strobe edge after reset stores the reference direction and produces no `rev_pulse`.
- R6: A rising strobe edge whose direction sample differs from the previous sample gives `rev_pulse` high for one cycle. An equal sample gives no pulse.
- R7: Reversals on consecutive strobes each give their own pulse, even when strobes are only two clock cycles apart.
- R8: `rev_pulse` reloads the count to RELOAD even if the count is nonzero. `ready_n` is high on the following cycle.
- R9: After the last `rev_pulse`, `ready_n` stays high for exactly RELOAD cycles, starting on the cycle after the pulse, and then stays low until the next reversal.
- R10: RELOAD = round(CLK_HZ × HOLD_US / 1,000,000), rounded to the nearest integer with halves rounded up. HOLD_US defaults to 18000.
- R11: `rev_pulse` is a register output and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| step_n | input | 1 | Step strobe, asynchronous, idles high and pulses low |
| dir | input | 1 | Head direction level, asynchronous |
| ready_n | output | 1 | Active-low ready, held high during the hold-off |
| rev_pulse | output | 1 | One-cycle pulse for each detected reversal |

## Verification
The checker assumes that `rst_n` is deasserted in step with the clock and that the two line inputs only change between clock edges. The bench meets both conditions by driving every input just after a falling clock edge. The properties also rely on strobe rising edges at the synchronizer output being at least two cycles apart, which is guaranteed by the need for a low sample before each high one. The stimulus uses the shortest such spacing, a one-cycle low followed by a one-cycle high, to exercise the tightest case. It also includes direction changes with no strobe, a reversal inside a running hold-off, and a reset asserted in the middle of a hold-off.

// File: rtl/dirrev_pkg.sv
package dirrev_pkg;
  // Clock cycles for a hold-off of us_val microseconds at hz, rounded to nearest.
  function automatic longint hold_cycles(input longint hz, input longint us_val);
    return (hz * us_val + 64'sd500000) / 64'sd1000000;
  endfunction
endpackage

// File: rtl/dirrev_sync_chain.sv
module dirrev_sync_chain #(
  parameter int          STAGES  = 2,
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dirrev_strobe_rise.sv
module dirrev_strobe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // Idle level of the strobe is high, so the history resets high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/dirrev_compare.sv
module dirrev_compare (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic dir_s,
  output logic ref_valid,
  output logic rev_pulse
);
  logic ref_dir_q, ref_dir_d;
  logic valid_d;
  logic pulse_d;

  always_comb begin
    ref_dir_d = ref_dir_q;
    valid_d   = ref_valid;
    pulse_d   = 1'b0;
    if (sample_en) begin
      ref_dir_d = dir_s;
      valid_d   = 1'b1;
      pulse_d   = ref_valid & (dir_s ^ ref_dir_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_dir_q <= 1'b0;
      ref_valid <= 1'b0;
    end else if (sample_en) begin
      ref_dir_q <= ref_dir_d;
      ref_valid <= valid_d;
    end
  end

  // Registered so the pulse is formed only from settled samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rev_pulse <= 1'b0;
    else        rev_pulse <= pulse_d;
  end
endmodule

// File: rtl/dirrev_holdoff.sv
module dirrev_holdoff #(
  parameter int          CW     = 20,
  parameter int unsigned RELOAD = 900000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [CW-1:0] cnt,
  output logic          ready_n
);
  localparam logic [CW-1:0] FULL = CW'(RELOAD);

  logic          cnt_en;
  logic [CW-1:0] cnt_d;
  logic          busy_d;

  always_comb begin
    cnt_en = load | (cnt != '0);
    cnt_d  = load ? FULL : (cnt - 1'b1);
    busy_d = cnt_en ? (cnt_d != '0) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= FULL;
    else if (cnt_en) cnt <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_n <= 1'b1;
    else        ready_n <= busy_d;
  end
endmodule

// File: rtl/dirrev_ready_gate.sv
module dirrev_ready_gate #(
  parameter longint CLK_HZ   = 50_000_000,
  parameter longint HOLD_US  = 18_000,
  parameter int     SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_n,
  input  logic dir,
  output logic ready_n,
  output logic rev_pulse
);
  localparam longint      RELOAD_L = dirrev_pkg::hold_cycles(CLK_HZ, HOLD_US);
  localparam int unsigned RELOAD   = (RELOAD_L < 1) ? 1 : 32'(RELOAD_L);
  localparam int          CW       = $clog2(RELOAD + 1);

  logic [1:0]    line_sync;
  logic          step_rise;
  logic          ref_valid;
  logic [CW-1:0] hold_cnt;

  // Bit 1: strobe (idles high), bit 0: direction.
  dirrev_sync_chain #(.STAGES(SYNC_LEN), .W(2), .RST_VAL(2'b10)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({step_n, dir}),
    .sync_out (line_sync)
  );

  dirrev_strobe_rise u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (line_sync[1]),
    .rise  (step_rise)
  );

  dirrev_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (step_rise),
    .dir_s     (line_sync[0]),
    .ref_valid (ref_valid),
    .rev_pulse (rev_pulse)
  );

  dirrev_holdoff #(.CW(CW), .RELOAD(RELOAD)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rev_pulse),
    .cnt     (hold_cnt),
    .ready_n (ready_n)
  );
endmodule

// File: rtl/dirrev_ready_gate_chk.sv
module dirrev_ready_gate_chk #(
  parameter int          CW     = 20,
  parameter int unsigned RELOAD = 900000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rev_pulse,
  input logic          ready_n,
  input logic          step_rise,
  input logic          ref_valid,
  input logic [CW-1:0] cnt
);
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rev_pulse |=> !rev_pulse);

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rev_pulse |=> (cnt == CW'(RELOAD)) && ready_n);

  p_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev_pulse && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_idle_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev_pulse && cnt == '0) |=> (cnt == '0) && !ready_n);

  p_ready_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready_n == (cnt != '0));

  p_first_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && !ref_valid) |=> !rev_pulse);

  p_pulse_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rev_pulse |-> $past(step_rise) && $past(ref_valid));
endmodule

bind dirrev_ready_gate dirrev_ready_gate_chk #(.CW(CW), .RELOAD(RELOAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rev_pulse (rev_pulse),
  .ready_n   (ready_n),
  .step_rise (step_rise),
  .ref_valid (ref_valid),
  .cnt       (hold_cnt)
);

// File: tb/dirrev_ready_gate_test.sv
module dirrev_ready_gate_test;
  localparam time    CLK_PERIOD = 10ns;
  localparam longint T_CLK_HZ   = 10030;
  localparam longint T_HOLD_US  = 18000;
  // R10: bench-side rounding, halves up
  localparam int EXP_RELOAD = int'((T_CLK_HZ * T_HOLD_US + 500000) / 1000000);

  logic clk = 1'b0;
  logic rst_n, step_n, dir;
  wire  ready_n, rev_pulse;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R2";

  bit sh[$];
  bit dh[$];
  int m_cnt;
  bit m_pulse, m_valid, m_ref;
  int pulses_seen;
  int hi_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirrev_ready_gate #(.CLK_HZ(T_CLK_HZ), .HOLD_US(T_HOLD_US)) uut (
    .clk(clk), .rst_n(rst_n), .step_n(step_n), .dir(dir),
    .ready_n(ready_n), .rev_pulse(rev_pulse)
  );

  task automatic model_reset();
    sh.delete(); dh.delete();
    for (int i = 0; i < 3; i++) begin sh.push_back(1'b1); dh.push_back(1'b0); end
    m_cnt = EXP_RELOAD; m_pulse = 1'b0; m_valid = 1'b0; m_ref = 1'b0;
  endtask

  task automatic model_edge();
    int n, nc;
    bit rise, np;
    sh.push_back(step_n); dh.push_back(dir);
    n = sh.size() - 1;
    nc = m_pulse ? EXP_RELOAD : (m_cnt > 0 ? m_cnt - 1 : 0);
    rise = sh[n-2] && !sh[n-3];
    np = rise && m_valid && (dh[n-2] != m_ref);
    if (rise) begin m_ref = dh[n-2]; m_valid = 1'b1; end
    m_cnt = nc; m_pulse = np;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst_n) model_reset();
    else        model_edge();
    check(cur_req, ready_n, (m_cnt != 0) ? 1 : 0, "ready_n");
    check(cur_req, rev_pulse, m_pulse ? 1 : 0, "rev_pulse");
    if (rev_pulse) pulses_seen++;
    if (ready_n) hi_run++; else hi_run = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic strobe(input bit d, input int low_cyc, input int high_cyc);
    step_n = 1'b0; dir = d;
    ticks(low_cyc);
    step_n = 1'b1;
    ticks(high_cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; step_n = 1'b1; dir = 1'b0;
    model_reset();
    // R2: reset values
    cur_req = "R2";
    ticks(4);
    check("R2", ready_n, 1, "ready_n in reset");
    check("R2", rev_pulse, 0, "rev_pulse in reset");
    rst_n = 1'b1;
    hi_run = 0;
    ticks(EXP_RELOAD + 5);
    check("R1", ready_n, 0, "ready_n after start-up hold-off");

    // R5: first strobe sets reference only
    cur_req = "R5"; pulses_seen = 0;
    strobe(1'b1, 2, 6);
    check("R5", pulses_seen, 0, "pulses on first strobe");

    // R6: equal direction, no pulse
    cur_req = "R6"; pulses_seen = 0;
    for (int i = 0; i < 3; i++) strobe(1'b1, 3, 4);
    check("R6", pulses_seen, 0, "pulses with steady direction");

    // R4: direction moves without a rising strobe edge
    cur_req = "R4"; pulses_seen = 0;
    dir = 1'b0; ticks(5); dir = 1'b1; ticks(3); dir = 1'b0; ticks(4);
    step_n = 1'b0; ticks(3); dir = 1'b1; ticks(3);
    step_n = 1'b1; ticks(6);
    check("R4", pulses_seen, 0, "pulses without reversal at a rising edge");
    check("R4", ready_n, 0, "ready_n unchanged");

    // R3: latency from rising edge to pulse; R6 single reversal
    cur_req = "R3"; pulses_seen = 0;
    step_n = 1'b0; dir = 1'b0; ticks(3);
    step_n = 1'b1;
    lat = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (rev_pulse && lat == 0) lat = i + 1;
    end
    check("R3", lat, 3, "ticks from strobe rise to rev_pulse");
    check("R6", pulses_seen, 1, "pulses for one reversal");

    // R9 and R10: hold-off length after a reversal
    cur_req = "R9";
    ticks(EXP_RELOAD + 4);
    check("R9", ready_n, 0, "ready_n after hold-off");
    cur_req = "R10"; pulses_seen = 0; hi_run = 0;
    strobe(1'b1, 2, 2);
    begin
      int run;
      run = 0;
      for (int i = 0; i < EXP_RELOAD + 10; i++) begin
        tick();
        if (ready_n) run++;
      end
      check("R10", run, EXP_RELOAD, "ready_n high cycles");
    end

    // R8: reversal while counting restarts the hold-off
    cur_req = "R8"; pulses_seen = 0;
    strobe(1'b0, 2, 50);
    strobe(1'b1, 2, 2);
    ticks(EXP_RELOAD - 20);
    check("R8", ready_n, 1, "ready_n still high after restart");
    check("R8", pulses_seen, 2, "pulses for two reversals");
    ticks(30);

    // R7 and R11: back-to-back reversals at minimum spacing
    cur_req = "R7"; pulses_seen = 0;
    for (int i = 0; i < 6; i++) strobe((i % 2) == 0 ? 1'b0 : 1'b1, 1, 1);
    ticks(4);
    check("R7", pulses_seen, 6, "pulses for consecutive reversals");
    cur_req = "R11";
    ticks(EXP_RELOAD + 4);

    // R2: reset during a hold-off, then start-up hold-off again
    cur_req = "R2";
    strobe(1'b0, 2, 20);
    rst_n = 1'b0;
    ticks(3);
    check("R2", ready_n, 1, "ready_n in mid-run reset");
    rst_n = 1'b1;
    pulses_seen = 0;
    strobe(1'b1, 2, 4);
    check("R5", pulses_seen, 0, "first strobe after second reset");
    ticks(EXP_RELOAD);
    check("R2", ready_n, 0, "ready_n after start-up hold-off");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule